// File: doc/BRIEF.md
# Static Branch Fetch Controller

This block steers instruction fetch around conditional and unconditional branches in an in-order scalar pipeline. It owns the fetch program counter and applies one of four fixed policies, chosen by a two-bit mode input: hold fetch until the branch is settled, keep fetching down the fall-through path, jump to the target as soon as it is available, or execute one delay-slot instruction before settling. Each policy has its own stall, squash and redirect timing, so each policy loses its own number of cycles for each kind of branch.

Decode raises `dec_br_i` for one cycle when a branch is in decode (cycle k = 0). The target is given with it. The target is taken as known at the end of cycle `TGT_DLY-1`. The condition, read from `res_taken_i`, is sampled at the end of cycle `CND_DLY-1`. An unconditional branch settles when its target is known (D = `TGT_DLY`). A conditional branch settles when its condition is known (D = `CND_DLY`). One branch is handled at a time. The cycles lost to each branch are added to one of three saturating counters, chosen by the branch's class.

Top module: `brfetch_ctrl`

## Requirements
- R1: After reset, `fetch_pc_o` equals `RESET_PC`. `stall_o`, `squash_o`, `dec_hold_o` and `slot_err_o` are all 0, and the three penalty counters are 0.
- R2: In every cycle after reset, `fetch_pc_o` takes the value that `next_pc_o` had in the cycle before. When no branch is active, `next_pc_o` is `fetch_pc_o + 4` and `stall_o` is 0.
- R3: Mode 0 (hold). `stall_o` is 1 in cycles k = 0..D-1. The first valid fetch is in cycle D, at the target if the branch is taken (or unconditional) and at branch+4 otherwise. No squash is raised. The penalty is D for every branch class.
- R4: Mode 1 (fall-through). Fetch continues sequentially without stalls. A not-taken branch costs 0 cycles. For a taken (or unconditional) branch, cycle D fetches the target and the penalty is D.
- R5: Mode 2 (target-first). `stall_o` is 1 in cycles k < `TGT_DLY`, and cycle `TGT_DLY` fetches the target. A not-taken branch returns to branch+4 at cycle `CND_DLY`. The penalty is `TGT_DLY` for taken and unconditional branches, and `CND_DLY` for not-taken branches.
- R6: Mode 3 (delay slot). Cycle 0 always fetches branch+4 without a stall. Cycles 1..D-1 stall. Cycle D fetches the target if the branch is taken, or branch+8 if it is not. The penalty is D-1.
- R7: `squash_o` bit i marks the instruction fetched i cycles earlier, counting the current cycle as bit 0. It is raised only in the cycle where `next_pc_o` carries the redirect, never while stalled, and always as a block of low bits. It covers D instructions for a taken branch in mode 1, `CND_DLY-TGT_DLY` for a not-taken branch in mode 2, and none otherwise.
- R8: A branch in decode in the cycle after a mode-3 branch was accepted raises `slot_err_o`. It is not accepted and does not raise `dec_hold_o`, and the first branch completes unchanged.
- R9: A branch arriving in decode while another is in flight raises `dec_hold_o`. It is not accepted, and the in-flight branch completes unchanged.
- R10: The mode is read only in the cycle a branch is accepted. A change of `mode_i` while a branch is in flight has no effect on that branch.
- R11: Each branch adds its penalty to `pen_uncond_o`, `pen_ntaken_o` or `pen_taken_o`, chosen by its class. A counter stops at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy: 0 hold, 1 fall-through, 2 target-first, 3 delay slot |
| dec_br_i | input | 1 | A branch is in decode this cycle |
| dec_uncond_i | input | 1 | The branch in decode is unconditional |
| dec_tgt_i | input | PC_W | Target of the branch in decode |
| res_taken_i | input | 1 | Branch outcome, sampled at cycle CND_DLY-1 |
| fetch_pc_o | output | PC_W | Address fetched this cycle |
| next_pc_o | output | PC_W | Address to fetch next cycle |
| stall_o | output | 1 | This cycle's fetch slot is a bubble |
| squash_o | output | CND_DLY | Per-age kill mask for wrong-path fetches |
| dec_hold_o | output | 1 | Hold the branch in decode, one is already in flight |
| slot_err_o | output | 1 | Illegal branch in the delay slot |
| pen_uncond_o | output | CNT_W | Lost cycles, unconditional branches |
| pen_ntaken_o | output | CNT_W | Lost cycles, not-taken conditional branches |
| pen_taken_o | output | CNT_W | Lost cycles, taken conditional branches |

## Verification
The hardest situations to reach are the ones where something arrives while a branch is still in flight. These are a second branch in decode, a branch in the delay slot, and a change of mode. Each one only shows up in a narrow window between acceptance and settling. The stimulus sweeps every mode against every branch class and outcome. It then repeats single runs with exactly one of these events placed in cycle 1, and checks that the first branch's redirect timing and penalty do not change. Saturation is reached by feeding a long run of identical unconditional branches until the counter must clip.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int DLY_W = 4;  // branch delays up to 15 cycles
    localparam int NCLS  = 3;

    typedef enum logic [1:0] {
        POL_HOLD   = 2'd0,
        POL_FALL   = 2'd1,
        POL_TARGET = 2'd2,
        POL_SLOT   = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        CLS_UNCOND = 2'd0,
        CLS_NTAKEN = 2'd1,
        CLS_TAKEN  = 2'd2
    } cls_e;

    typedef struct packed {
        pol_e             mode;
        logic             uncond;
        logic [DLY_W-1:0] k;
    } ctx_t;

    function automatic cls_e class_of(input logic uncond, input logic taken);
        if (uncond)     return CLS_UNCOND;
        else if (taken) return CLS_TAKEN;
        else            return CLS_NTAKEN;
    endfunction

endpackage

// File: rtl/brf_seq.sv
module brf_seq
    import brf_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            fin,
    input  pol_e            mode_i,
    input  logic            uncond_i,
    input  logic [PC_W-1:0] tgt_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            busy_q,
    output ctx_t            cur,
    output logic [PC_W-1:0] cur_tgt,
    output logic [PC_W-1:0] cur_seq
);

    ctx_t            ctx_q;
    logic [PC_W-1:0] tgt_q;
    logic [PC_W-1:0] seq_q;

    // While idle, the live decode inputs form the context; once busy, the latched copy does.
    always_comb begin
        if (busy_q) begin
            cur     = ctx_q;
            cur_tgt = tgt_q;
            cur_seq = seq_q;
        end else begin
            cur.mode   = mode_i;
            cur.uncond = uncond_i;
            cur.k      = '0;
            cur_tgt    = tgt_i;
            cur_seq    = pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctx_q  <= '0;
            tgt_q  <= '0;
            seq_q  <= '0;
        end else if ((accept || busy_q) && !fin) begin
            busy_q       <= 1'b1;
            ctx_q.mode   <= cur.mode;
            ctx_q.uncond <= cur.uncond;
            ctx_q.k      <= cur.k + DLY_W'(1);
            tgt_q        <= cur_tgt;
            seq_q        <= cur_seq;
        end else if (fin) begin
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/brf_policy.sv
module brf_policy
    import brf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int TGT_DLY = 2,
    parameter int CND_DLY = 3,
    parameter int SQ_W    = CND_DLY
) (
    input  ctx_t             cur,
    input  logic             active,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PC_W-1:0]  seq,
    output logic             stall,
    output logic             fin,
    output logic [PC_W-1:0]  nxt,
    output logic [SQ_W-1:0]  squash,
    output logic [DLY_W-1:0] pen,
    output cls_e             cls
);

    localparam int SPAN = CND_DLY - TGT_DLY;

    function automatic logic [SQ_W-1:0] low_mask(input int n);
        logic [SQ_W-1:0] m;
        for (int i = 0; i < SQ_W; i++) m[i] = (i < n);
        return m;
    endfunction

    int   d;
    int   kk;
    logic tk;

    always_comb begin
        d      = cur.uncond ? TGT_DLY : CND_DLY;
        kk     = int'(cur.k);
        tk     = cur.uncond | res_taken;
        fin    = active && (kk == d - 1);
        cls    = class_of(cur.uncond, res_taken);
        squash = '0;
        pen    = '0;
        stall  = 1'b0;

        if (active) begin
            unique case (cur.mode)
                POL_HOLD:   stall = 1'b1;
                POL_FALL:   stall = 1'b0;
                POL_TARGET: stall = (kk < TGT_DLY);
                POL_SLOT:   stall = (kk != 0);
                default:    stall = 1'b0;
            endcase
        end

        nxt = stall ? pc : pc + PC_W'(4);

        if (active) begin
            unique case (cur.mode)
                POL_HOLD: begin
                    if (fin && tk) nxt = tgt;
                    pen = DLY_W'(d);
                end
                POL_FALL: begin
                    if (fin && tk) begin
                        nxt    = tgt;
                        squash = low_mask(d);
                    end
                    pen = tk ? DLY_W'(d) : '0;
                end
                POL_TARGET: begin
                    if (kk == TGT_DLY - 1) nxt = tgt;
                    if (fin && !tk) begin
                        nxt    = seq;
                        squash = low_mask(SPAN);
                    end
                    pen = tk ? DLY_W'(TGT_DLY) : DLY_W'(CND_DLY);
                end
                POL_SLOT: begin
                    if (fin && tk) nxt = tgt;
                    pen = DLY_W'(d - 1);
                end
                default: pen = '0;
            endcase
        end
    end

endmodule

// File: rtl/brf_satcnt.sv
module brf_satcnt
    import brf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DLY_W-1:0] add,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W:0] TOP = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    always_comb sum = {1'b0, cnt} + (CNT_W + 1)'(add);

    always_ff @(posedge clk) begin
        if (rst)     cnt <= '0;
        else if (en) cnt <= (sum > TOP) ? TOP[CNT_W-1:0] : sum[CNT_W-1:0];
    end

endmodule

// File: rtl/brfetch_ctrl.sv
module brfetch_ctrl
    import brf_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter int              TGT_DLY  = 2,
    parameter int              CND_DLY  = 3,
    parameter int              CNT_W    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_i,
    input  logic               dec_br_i,
    input  logic               dec_uncond_i,
    input  logic [PC_W-1:0]    dec_tgt_i,
    input  logic               res_taken_i,
    output logic [PC_W-1:0]    fetch_pc_o,
    output logic [PC_W-1:0]    next_pc_o,
    output logic               stall_o,
    output logic [CND_DLY-1:0] squash_o,
    output logic               dec_hold_o,
    output logic               slot_err_o,
    output logic [CNT_W-1:0]   pen_uncond_o,
    output logic [CNT_W-1:0]   pen_ntaken_o,
    output logic [CNT_W-1:0]   pen_taken_o
);

    localparam int SQ_W = CND_DLY;

    logic             busy_q;
    logic             slot_q;
    logic             accept;
    logic             active;
    logic             fin;
    ctx_t             cur;
    pol_e             cur_mode;
    logic [PC_W-1:0]  cur_tgt;
    logic [PC_W-1:0]  cur_seq;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_d;
    logic [DLY_W-1:0] pen;
    cls_e             cls;
    logic [CNT_W-1:0] cnt [NCLS];

    assign accept     = !busy_q && dec_br_i && !slot_q;
    assign active     = busy_q || accept;
    assign dec_hold_o = busy_q && dec_br_i && !slot_q;
    assign slot_err_o = slot_q && dec_br_i;
    assign cur_mode   = cur.mode;

    brf_seq #(.PC_W(PC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .fin      (fin),
        .mode_i   (pol_e'(mode_i)),
        .uncond_i (dec_uncond_i),
        .tgt_i    (dec_tgt_i),
        .pc_i     (pc_q),
        .busy_q   (busy_q),
        .cur      (cur),
        .cur_tgt  (cur_tgt),
        .cur_seq  (cur_seq)
    );

    brf_policy #(
        .PC_W    (PC_W),
        .TGT_DLY (TGT_DLY),
        .CND_DLY (CND_DLY),
        .SQ_W    (SQ_W)
    ) u_pol (
        .cur       (cur),
        .active    (active),
        .res_taken (res_taken_i),
        .pc        (pc_q),
        .tgt       (cur_tgt),
        .seq       (cur_seq),
        .stall     (stall_o),
        .fin       (fin),
        .nxt       (pc_d),
        .squash    (squash_o),
        .pen       (pen),
        .cls       (cls)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cnt
        brf_satcnt #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .en  (fin && (cls == cls_e'(c))),
            .add (pen),
            .cnt (cnt[c])
        );
    end

    assign pen_uncond_o = cnt[CLS_UNCOND];
    assign pen_ntaken_o = cnt[CLS_NTAKEN];
    assign pen_taken_o  = cnt[CLS_TAKEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            slot_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            slot_q <= accept && (pol_e'(mode_i) == POL_SLOT);
        end
    end

    assign fetch_pc_o = pc_q;
    assign next_pc_o  = pc_d;

endmodule

// File: rtl/brfetch_ctrl_chk.sv
module brfetch_ctrl_chk
    import brf_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int CND_DLY = 3,
    parameter int CNT_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    fetch_pc_o,
    input logic [PC_W-1:0]    next_pc_o,
    input logic               stall_o,
    input logic [CND_DLY-1:0] squash_o,
    input logic               dec_hold_o,
    input logic               slot_err_o,
    input logic               busy,
    input pol_e               mode_now,
    input logic [CNT_W-1:0]   c_unc,
    input logic [CNT_W-1:0]   c_nt,
    input logic [CNT_W-1:0]   c_tk
);

    p_pc_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> fetch_pc_o == $past(next_pc_o));

    p_squash_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (squash_o != '0) |-> !stall_o);

    p_squash_contig_r7: assert property (@(posedge clk) disable iff (rst)
        ((squash_o & (squash_o + 1'b1)) == '0));

    p_err_not_held_r8: assert property (@(posedge clk) disable iff (rst)
        slot_err_o |-> !dec_hold_o);

    p_hold_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
        dec_hold_o |-> busy);

    p_mode_locked_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_now));

    p_unc_mono_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_unc >= $past(c_unc));

    p_nt_mono_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_nt >= $past(c_nt));

    p_tk_mono_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> c_tk >= $past(c_tk));

endmodule

bind brfetch_ctrl brfetch_ctrl_chk #(
    .PC_W    (PC_W),
    .CND_DLY (CND_DLY),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc_o (fetch_pc_o),
    .next_pc_o  (next_pc_o),
    .stall_o    (stall_o),
    .squash_o   (squash_o),
    .dec_hold_o (dec_hold_o),
    .slot_err_o (slot_err_o),
    .busy       (busy_q),
    .mode_now   (cur_mode),
    .c_unc      (pen_uncond_o),
    .c_nt       (pen_ntaken_o),
    .c_tk       (pen_taken_o)
);

// File: tb/brfetch_ctrl_tb.sv
module brfetch_ctrl_tb;

    localparam int PC_W = 32;
    localparam int TD   = 2;
    localparam int CD   = 3;
    localparam int CW   = 8;
    localparam int CMAX = 255;
    localparam logic [31:0] RPC = 32'h0000_0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'd0;
    logic          dec_br_i = 1'b0;
    logic          dec_uncond_i = 1'b0;
    logic [31:0]   dec_tgt_i = '0;
    logic          res_taken_i = 1'b0;
    logic [31:0]   fetch_pc_o;
    logic [31:0]   next_pc_o;
    logic          stall_o;
    logic [CD-1:0] squash_o;
    logic          dec_hold_o;
    logic          slot_err_o;
    logic [CW-1:0] pen_uncond_o;
    logic [CW-1:0] pen_ntaken_o;
    logic [CW-1:0] pen_taken_o;

    int checks = 0;
    int fails  = 0;
    int nbr    = 0;
    bit done   = 0;
    int exp_cnt [3];

    always #4 clk = ~clk;  // 8 ns period

    brfetch_ctrl #(
        .PC_W(PC_W), .TGT_DLY(TD), .CND_DLY(CD), .CNT_W(CW), .RESET_PC(RPC)
    ) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .dec_br_i(dec_br_i),
        .dec_uncond_i(dec_uncond_i), .dec_tgt_i(dec_tgt_i), .res_taken_i(res_taken_i),
        .fetch_pc_o(fetch_pc_o), .next_pc_o(next_pc_o), .stall_o(stall_o),
        .squash_o(squash_o), .dec_hold_o(dec_hold_o), .slot_err_o(slot_err_o),
        .pen_uncond_o(pen_uncond_o), .pen_ntaken_o(pen_ntaken_o), .pen_taken_o(pen_taken_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int exp_pen(input int m, input bit unc, input bit tk);
        int d = unc ? TD : CD;
        case (m)
            0: return d;
            1: return (unc || tk) ? d : 0;
            2: return (unc || tk) ? TD : CD;
            default: return d - 1;
        endcase
    endfunction

    function automatic int exp_sq(input int m, input bit unc, input bit tk);
        int d = unc ? TD : CD;
        if (m == 1 && (unc || tk)) return d;
        if (m == 2 && !unc && !tk) return CD - TD;
        return 0;
    endfunction

    function automatic int cls_idx(input bit unc, input bit tk);
        if (unc) return 0;
        return tk ? 2 : 1;
    endfunction

    function automatic int read_cnt(input int c);
        case (c)
            0: return int'(pen_uncond_o);
            1: return int'(pen_ntaken_o);
            default: return int'(pen_taken_o);
        endcase
    endfunction

    // inj: 0 none, 1 mode change at k=1, 2 second branch at k=1, 3 branch in delay slot
    task automatic run_branch(input int m, input bit unc, input bit tk, input int inj);
        logic [31:0] tgt, b4, good;
        int first, sqn, pe, c;
        bit slot_ok;
        first = -1; sqn = 0; slot_ok = 1;
        nbr++;
        tgt = 32'h0010_0000 + 32'(nbr) * 32'h400;
        @(negedge clk);
        mode_i = 2'(m); dec_br_i = 1; dec_uncond_i = unc; res_taken_i = tk; dec_tgt_i = tgt;
        #1;
        b4 = fetch_pc_o;
        good = (unc || tk) ? tgt : ((m == 3) ? b4 + 4 : b4);
        for (int k = 0; k < 10; k++) begin
            if (k > 0) begin
                @(negedge clk);
                dec_br_i = 0;
                if (k == 1 && inj == 1) mode_i = 2'd1;
                if (k == 1 && inj >= 2) begin
                    dec_br_i = 1; dec_tgt_i = 32'h00F0_0000;
                end
                #1;
                if (k == 1 && inj == 2) begin
                    chk(dec_hold_o == 1, "R9", "hold on second branch", dec_hold_o, 1);
                    chk(slot_err_o == 0, "R9", "no slot error", slot_err_o, 0);
                end
                if (k == 1 && inj == 3) begin
                    chk(slot_err_o == 1, "R8", "slot branch flagged", slot_err_o, 1);
                    chk(dec_hold_o == 0, "R8", "slot branch not held", dec_hold_o, 0);
                end
            end
            if (m == 3 && k == 0) slot_ok = (fetch_pc_o == b4) && !stall_o;
            if (first < 0 && !stall_o && fetch_pc_o == good && !(m == 3 && k == 0)) first = k;
            sqn += $countones(squash_o);
        end
        pe = exp_pen(m, unc, tk);
        if (m == 3) begin
            chk(slot_ok, "R6", "delay slot fetched", 0, 1);
            chk(first - 1 == pe, "R6", "post-slot penalty", first - 1, pe);
        end else begin
            chk(first == pe, req_of(m), "penalty to good fetch", first, pe);
        end
        chk(sqn == exp_sq(m, unc, tk), "R7", "squash count", sqn, exp_sq(m, unc, tk));
        c = cls_idx(unc, tk);
        exp_cnt[c] = (exp_cnt[c] + pe > CMAX) ? CMAX : exp_cnt[c] + pe;
        chk(read_cnt(c) == exp_cnt[c], "R11", "class counter", read_cnt(c), exp_cnt[c]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] p0;
        for (int i = 0; i < 3; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(fetch_pc_o == RPC, "R1", "reset pc", fetch_pc_o, RPC);
        chk(!stall_o && squash_o == 0 && !dec_hold_o && !slot_err_o, "R1", "reset flags", 1, 0);
        chk(pen_uncond_o == 0 && pen_ntaken_o == 0 && pen_taken_o == 0, "R1", "reset counters", 1, 0);
        // R2: sequential fetch
        p0 = fetch_pc_o;
        chk(next_pc_o == p0 + 4, "R2", "next pc idle", next_pc_o, p0 + 4);
        @(negedge clk); #1;
        chk(fetch_pc_o == p0 + 4, "R2", "pc advance", fetch_pc_o, p0 + 4);

        // sweep of every policy, class and outcome
        for (int m = 0; m < 4; m++)
            for (int u = 0; u < 2; u++)
                for (int t = 0; t < 2; t++)
                    run_branch(m, u[0], t[0], 0);

        // R10: mode change mid-flight (hold policy, taken)
        run_branch(0, 0, 1, 1);
        // R9: second branch while busy (hold policy, not taken)
        run_branch(0, 0, 0, 2);
        // R8: branch in the delay slot
        run_branch(3, 0, 1, 3);

        // R11: saturation of the unconditional counter
        for (int i = 0; i < 130; i++) run_branch(0, 1, 0, 0);
        chk(pen_uncond_o == CW'(CMAX), "R11", "saturated", pen_uncond_o, CMAX);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule